// File: doc/BRIEF.md
# Seven-Source Prioritized Vectored Interrupt Controller

This block collects interrupt requests from seven sources of a small microcontroller: two active-low external pins, three timers, a serial port and a capture/compare array. It masks them with one global enable and per-source enables, and ranks them by a two-bit programmable level. A fixed order breaks ties within a level. The winner is offered to the CPU as a request. When the CPU acknowledges, the block returns the matching vector address and pulses clear strobes for the flags that hardware clears.

The block keeps a record of the levels now in service. A new request is offered only when its level is strictly above every level in service, so higher-level work preempts lower-level work. A return strobe from the CPU releases the highest level in service. Each external pin can work in one of two modes. In level mode it requests while the pin is low. In edge mode it latches a falling edge and holds it until that source is vectored.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq_req_o`, `vec_valid_o`, `clr_tmr0_o` and `clr_tmr1_o` are all 0 and no level is in service.
- R2: `irq_en_i[7]` is a global enable. While it is 0, `irq_req_o` stays 0. Bits 0..6 enable the individual sources, each in this order: bit 0 ext0, bit 1 timer0, bit 2 ext1, bit 3 timer1, bit 4 serial, bit 5 timer2, bit 6 capture array. A source with its bit at 0 is never offered.
- R3: The level of source i is {`prio_hi_i[i]`,`prio_lo_i[i]`}, where 3 is the highest and 0 the lowest. Among enabled pending sources, one at a higher level wins regardless of its position in the fixed order.
- R4: Among pending sources at the same level, the winner is the lowest bit index from R2: ext0, then timer0, ext1, timer1, serial, timer2, and last the capture array.
- R5: The vector is 0xFF0003 + 8 × index, where index is the bit index from R2. This gives 0xFF0003 for ext0 and 0xFF0033 for the capture array.
- R6: The timer2 request is `tmr2_ovf_i` OR `tmr2_ext_i`. The serial request is `ser_rx_i` OR `ser_tx_i`.
- R7: When `irq_ack_i` is 1 in a cycle with `irq_req_o` at 1, `vec_valid_o` is 1 in the next cycle only, with `vec_addr_o` holding the vector of the source that was offered. `irq_req_o` is 0 during that cycle.
- R8: `clr_tmr0_o` and `clr_tmr1_o` pulse together with `vec_valid_o` when timer0 or timer1, respectively, is vectored. No strobe is raised for timer2, serial or the capture array.
- R9: When `ext_edge_i[k]` is 1, a falling edge on `ext_n_i[k]` is latched as a request that survives the pin rising again. The latch is cleared when that source is vectored. If a new edge is detected in the same cycle as the clear, the new edge wins. When `ext_edge_i[k]` is 0, the request follows the synchronized pin being low and is never cleared by vectoring.
- R10: A request is offered only if its level is strictly higher than the highest level in service. Acknowledge marks the granted level as in service. `reti_i` releases the highest level in service.
- R11: An `irq_ack_i` while `irq_req_o` is 0 has no effect: no vector is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_n_i | input | 2 | External request pins, active low, asynchronous |
| ext_edge_i | input | 2 | Per pin: 1 = falling-edge mode, 0 = level mode |
| tmr0_ovf_i | input | 1 | Timer0 overflow flag |
| tmr1_ovf_i | input | 1 | Timer1 overflow flag |
| ser_rx_i | input | 1 | Serial receive flag |
| ser_tx_i | input | 1 | Serial transmit flag |
| tmr2_ovf_i | input | 1 | Timer2 overflow flag |
| tmr2_ext_i | input | 1 | Timer2 external flag |
| cca_flag_i | input | 1 | Capture/compare array flag |
| irq_en_i | input | 8 | Enables: bit 7 global, bits 6..0 per source |
| prio_hi_i | input | 7 | Upper level bit per source |
| prio_lo_i | input | 7 | Lower level bit per source |
| irq_req_o | output | 1 | Request to the CPU |
| irq_ack_i | input | 1 | CPU acknowledge |
| reti_i | input | 1 | CPU return-from-service strobe |
| vec_valid_o | output | 1 | Vector valid, one cycle |
| vec_addr_o | output | 24 | Vector address |
| clr_tmr0_o | output | 1 | Clear strobe for the timer0 flag |
| clr_tmr1_o | output | 1 | Clear strobe for the timer1 flag |

## Verification
An external edge latch can be set by a new falling edge in the same cycle as it is cleared by vectoring its own source. The bench provokes this by timing a second falling edge on ext0 so that it reaches the latch in exactly the cycle of the acknowledge. The outcome is judged after a return strobe empties the in-service record: the request must be offered again, which shows the new edge outranked the clear. The bench also checks that the vector issued for the acknowledged edge was still the ext0 address.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int IRQ_SRC = 7;
   localparam int LVL_W   = 2;
   localparam int IDX_W   = 3;
   localparam int NUM_LVL = 1 << LVL_W;

   typedef enum logic [IDX_W-1:0] {
      SRC_EXT0 = 3'd0,
      SRC_TMR0 = 3'd1,
      SRC_EXT1 = 3'd2,
      SRC_TMR1 = 3'd3,
      SRC_SER  = 3'd4,
      SRC_TMR2 = 3'd5,
      SRC_CCA  = 3'd6
   } src_e;
endpackage

// File: rtl/irqc_ext_sense.sv
module irqc_ext_sense #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n_i,
   input  logic edge_mode_i,
   input  logic clr_i,
   output logic req_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irqc_ext_sense: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   latch_q;
   logic                   synced;
   logic                   fall;

   assign synced = sync_q[SYNC_STAGES-1];
   assign fall   = prev_q & ~synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n_i};
         prev_q <= synced;
      end
   end

   // new edge outranks the clear from vectoring
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            latch_q <= 1'b0;
      else if (!edge_mode_i) latch_q <= 1'b0;
      else if (fall)         latch_q <= 1'b1;
      else if (clr_i)        latch_q <= 1'b0;
   end

   assign req_o = edge_mode_i ? latch_q : ~synced;

   // R9
   edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode_i && fall) |=> (req_o || !edge_mode_i));
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
   parameter int N     = 7,
   parameter int LVL_W = 2,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N-1:0]              req_i,
   input  logic [N-1:0][LVL_W-1:0]   lvl_i,
   output logic                      hit_o,
   output logic [IDX_W-1:0]          idx_o,
   output logic [LVL_W-1:0]          lvl_o
);
   // scan from the last index down; ">=" lets a lower index take a tie
   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      lvl_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i] && (!hit_o || lvl_i[i] >= lvl_o)) begin
            hit_o = 1'b1;
            idx_o = IDX_W'(i);
            lvl_o = lvl_i[i];
         end
      end
   end

   // R3
   pick_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (req_i[idx_o] && lvl_i[idx_o] == lvl_o));
endmodule

// File: rtl/irqc_lvl_track.sv
module irqc_lvl_track #(
   parameter int LVL_W = 2,
   localparam int NUM_LVL = 1 << LVL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [LVL_W-1:0] push_lvl_i,
   input  logic             pop_i,
   output logic [LVL_W:0]   rank_o
);
   logic [NUM_LVL-1:0] mask_q;
   logic [NUM_LVL-1:0] top_hot;
   logic [NUM_LVL-1:0] push_hot;

   always_comb begin
      top_hot = '0;
      rank_o  = '0;
      for (int i = 0; i < NUM_LVL; i++) begin
         if (mask_q[i]) begin
            top_hot = NUM_LVL'(1) << i;
            rank_o  = (LVL_W + 1)'(i + 1);
         end
      end
   end

   assign push_hot = push_i ? (NUM_LVL'(1) << push_lvl_i) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= (mask_q & ~(pop_i ? top_hot : '0)) | push_hot;
   end

   // R10
   push_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> ({1'b0, push_lvl_i} + (LVL_W + 1)'(1) > rank_o));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irqc_pkg::*;
#(
   parameter int          SYNC_STAGES = 2,
   parameter int          ADDR_W      = 24,
   parameter logic [23:0] VEC_BASE    = 24'hFF0003,
   parameter int          VEC_STEP    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        ext_n_i,
   input  logic [1:0]        ext_edge_i,
   input  logic              tmr0_ovf_i,
   input  logic              tmr1_ovf_i,
   input  logic              ser_rx_i,
   input  logic              ser_tx_i,
   input  logic              tmr2_ovf_i,
   input  logic              tmr2_ext_i,
   input  logic              cca_flag_i,
   input  logic [7:0]        irq_en_i,
   input  logic [6:0]        prio_hi_i,
   input  logic [6:0]        prio_lo_i,
   output logic              irq_req_o,
   input  logic              irq_ack_i,
   input  logic              reti_i,
   output logic              vec_valid_o,
   output logic [23:0]       vec_addr_o,
   output logic              clr_tmr0_o,
   output logic              clr_tmr1_o
);
   if (ADDR_W != 24) begin : g_bad_addr
      $error("irq_vector_ctrl: ADDR_W must be 24");
   end
   if (VEC_STEP < 1) begin : g_bad_step
      $error("irq_vector_ctrl: VEC_STEP must be positive");
   end

   logic [1:0]                    ext_req;
   logic [1:0]                    ext_clr;
   logic [IRQ_SRC-1:0]            raw_req;
   logic [IRQ_SRC-1:0]            elig;
   logic [IRQ_SRC-1:0][LVL_W-1:0] src_lvl;
   logic                          win_hit;
   logic [IDX_W-1:0]              win_idx;
   logic [LVL_W-1:0]              win_lvl;
   logic [LVL_W:0]                cur_rank;
   logic                          grant_ok;
   logic                          take;
   logic                          vec_valid_q;
   logic [ADDR_W-1:0]             vec_addr_q;
   logic                          clr0_q;
   logic                          clr1_q;

   for (genvar k = 0; k < 2; k++) begin : g_ext
      irqc_ext_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
         .clk         (clk),
         .rst_n       (rst_n),
         .pin_n_i     (ext_n_i[k]),
         .edge_mode_i (ext_edge_i[k]),
         .clr_i       (ext_clr[k]),
         .req_o       (ext_req[k])
      );
      assign ext_clr[k] = take && (win_idx == (k == 0 ? IDX_W'(SRC_EXT0) : IDX_W'(SRC_EXT1)));
   end

   always_comb begin
      raw_req           = '0;
      raw_req[SRC_EXT0] = ext_req[0];
      raw_req[SRC_TMR0] = tmr0_ovf_i;
      raw_req[SRC_EXT1] = ext_req[1];
      raw_req[SRC_TMR1] = tmr1_ovf_i;
      raw_req[SRC_SER]  = ser_rx_i | ser_tx_i;
      raw_req[SRC_TMR2] = tmr2_ovf_i | tmr2_ext_i;
      raw_req[SRC_CCA]  = cca_flag_i;
   end

   assign elig = raw_req & irq_en_i[IRQ_SRC-1:0] & {IRQ_SRC{irq_en_i[7]}};

   for (genvar i = 0; i < IRQ_SRC; i++) begin : g_lvl
      assign src_lvl[i] = {prio_hi_i[i], prio_lo_i[i]};
   end

   irqc_pick #(.N(IRQ_SRC), .LVL_W(LVL_W)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (elig),
      .lvl_i (src_lvl),
      .hit_o (win_hit),
      .idx_o (win_idx),
      .lvl_o (win_lvl)
   );

   irqc_lvl_track #(.LVL_W(LVL_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (take),
      .push_lvl_i (win_lvl),
      .pop_i      (reti_i),
      .rank_o     (cur_rank)
   );

   assign grant_ok = win_hit && !vec_valid_q &&
                     ({1'b0, win_lvl} + (LVL_W + 1)'(1) > cur_rank);
   assign take     = irq_ack_i && grant_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_valid_q <= 1'b0;
         vec_addr_q  <= '0;
         clr0_q      <= 1'b0;
         clr1_q      <= 1'b0;
      end else begin
         vec_valid_q <= take;
         clr0_q      <= take && (win_idx == IDX_W'(SRC_TMR0));
         clr1_q      <= take && (win_idx == IDX_W'(SRC_TMR1));
         if (take) vec_addr_q <= VEC_BASE + ADDR_W'(win_idx) * ADDR_W'(VEC_STEP);
      end
   end

   assign irq_req_o   = grant_ok;
   assign vec_valid_o = vec_valid_q;
   assign vec_addr_o  = vec_addr_q;
   assign clr_tmr0_o  = clr0_q;
   assign clr_tmr1_o  = clr1_q;

   // R7
   vec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o |=> !vec_valid_o);
   // R7
   hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o |-> !irq_req_o);
   // R8
   strobe_with_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_tmr0_o || clr_tmr1_o) |-> (vec_valid_o && !(clr_tmr0_o && clr_tmr1_o)));
   // R11
   ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack_i && !irq_req_o) |=> !vec_valid_o);
   // R2
   global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_i[7] |-> !irq_req_o);
   // R10
   in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o |-> (cur_rank != '0));
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ext_n = 2'b11;
   logic [1:0]  ext_edge = 2'b00;
   logic        t0 = 0, t1 = 0, srx = 0, stx = 0, t2o = 0, t2e = 0, cca = 0;
   logic [7:0]  en = 8'h00;
   logic [6:0]  phi = 7'h00, plo = 7'h00;
   logic        ack = 0, reti = 0;
   logic        req, vval, c0, c1;
   logic [23:0] vaddr;
   int          total = 0, bad = 0;
   bit          done = 0;

   always #5 clk = ~clk;

   irq_vector_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .ext_n_i(ext_n), .ext_edge_i(ext_edge),
      .tmr0_ovf_i(t0), .tmr1_ovf_i(t1), .ser_rx_i(srx), .ser_tx_i(stx),
      .tmr2_ovf_i(t2o), .tmr2_ext_i(t2e), .cca_flag_i(cca),
      .irq_en_i(en), .prio_hi_i(phi), .prio_lo_i(plo),
      .irq_req_o(req), .irq_ack_i(ack), .reti_i(reti),
      .vec_valid_o(vval), .vec_addr_o(vaddr), .clr_tmr0_o(c0), .clr_tmr1_o(c1));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; ext_n = 2'b11; ext_edge = 0; en = 0; phi = 0; plo = 0;
      t0 = 0; t1 = 0; srx = 0; stx = 0; t2o = 0; t2e = 0; cca = 0; ack = 0; reti = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic pulse_reti();
      reti = 1; @(negedge clk); reti = 0;
   endtask

   // acknowledge at a negedge; returns the vector and strobes of the next cycle
   task automatic do_ack(string tag, output logic [23:0] a, output logic s0, output logic s1);
      check({tag, " R7 req before ack"}, req, 1);
      ack = 1; @(negedge clk); ack = 0;
      check({tag, " R7 vec valid"}, vval, 1);
      check({tag, " R7 req held low"}, req, 0);
      a = vaddr; s0 = c0; s1 = c1;
      @(negedge clk);
      check({tag, " R7 one-cycle vec"}, vval, 0);
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 req", req, 0);
      check("R1 vval", vval, 0);
      check("R1 strobes", {c0, c1}, 0);
   endtask

   task automatic t_global();
      do_reset();
      t0 = 1; en = 8'h02; @(negedge clk);
      check("R2 global off", req, 0);
      en = 8'h82; @(negedge clk);
      check("R2 global on", req, 1);
      en = 8'h80; @(negedge clk);
      check("R2 source off", req, 0);
   endtask

   task automatic t_order();
      logic [23:0] a; logic s0, s1;
      do_reset();
      en = 8'hFA; t0 = 1; t1 = 1; srx = 1; t2o = 1; cca = 1; @(negedge clk);
      do_ack("R4 t0", a, s0, s1); t0 = 0;
      check("R4 R5 t0 vec", a, 24'hFF000B); check("R8 t0 strobes", {s0, s1}, 2'b10);
      pulse_reti();
      do_ack("R4 t1", a, s0, s1); t1 = 0;
      check("R4 R5 t1 vec", a, 24'hFF001B); check("R8 t1 strobes", {s0, s1}, 2'b01);
      pulse_reti();
      do_ack("R4 ser", a, s0, s1); srx = 0;
      check("R4 R5 ser vec", a, 24'hFF0023); check("R8 ser no strobe", {s0, s1}, 0);
      pulse_reti();
      do_ack("R4 t2", a, s0, s1); t2o = 0;
      check("R4 R5 t2 vec", a, 24'hFF002B); check("R8 t2 no strobe", {s0, s1}, 0);
      pulse_reti();
      do_ack("R4 cca", a, s0, s1); cca = 0;
      check("R4 R5 cca vec", a, 24'hFF0033); check("R8 cca no strobe", {s0, s1}, 0);
      pulse_reti();
   endtask

   task automatic t_level();
      logic [23:0] a; logic s0, s1;
      do_reset();
      en = 8'hC2; t0 = 1; cca = 1; phi = 7'h40; plo = 7'h40; @(negedge clk);
      do_ack("R3", a, s0, s1);
      check("R3 higher level wins", a, 24'hFF0033);
   endtask

   task automatic t_or();
      logic [23:0] a; logic s0, s1;
      do_reset();
      en = 8'hB0; t2e = 1; @(negedge clk);
      do_ack("R6 t2 ext", a, s0, s1);
      check("R6 t2 ext flag vec", a, 24'hFF002B);
      t2e = 0; pulse_reti();
      stx = 1; @(negedge clk);
      check("R6 ser tx req", req, 1);
   endtask

   task automatic t_ext_level();
      logic [23:0] a; logic s0, s1;
      do_reset();
      en = 8'h84; ext_n[1] = 0; repeat (4) @(negedge clk);
      do_ack("R9 lvl", a, s0, s1);
      check("R5 ext1 vec", a, 24'hFF0013);
      pulse_reti();
      check("R9 level not cleared", req, 1);
      ext_n[1] = 1; repeat (4) @(negedge clk);
      check("R9 level follows pin", req, 0);
   endtask

   task automatic t_ext_edge();
      logic [23:0] a; logic s0, s1;
      do_reset();
      en = 8'h81; ext_edge[0] = 1;
      ext_n[0] = 0; repeat (4) @(negedge clk); ext_n[0] = 1; repeat (4) @(negedge clk);
      check("R9 edge latched", req, 1);
      do_ack("R9 edge", a, s0, s1);
      check("R5 ext0 vec", a, 24'hFF0003);
      pulse_reti();
      check("R9 edge cleared", req, 0);
   endtask

   task automatic t_preempt();
      logic [23:0] a; logic s0, s1;
      do_reset();
      en = 8'h8E; plo = 7'h0A; phi = 7'h04;
      t1 = 1; @(negedge clk);
      do_ack("R10 t1", a, s0, s1); t1 = 0;
      check("R10 t1 vec", a, 24'hFF001B);
      t0 = 1; repeat (2) @(negedge clk);
      check("R10 equal level blocked", req, 0);
      ext_n[1] = 0; repeat (4) @(negedge clk);
      check("R10 higher level preempts", req, 1);
      do_ack("R10 ext1", a, s0, s1);
      check("R10 ext1 vec", a, 24'hFF0013);
      ext_n[1] = 1; repeat (4) @(negedge clk);
      check("R10 both in service", req, 0);
      pulse_reti();
      check("R10 one level left", req, 0);
      pulse_reti();
      check("R10 all released", req, 1);
      do_ack("R10 t0", a, s0, s1); t0 = 0;
      check("R10 t0 vec", a, 24'hFF000B);
   endtask

   task automatic t_ack_ignored();
      do_reset();
      en = 8'hFF; ack = 1; @(negedge clk); ack = 0;
      check("R11 no vec", vval, 0);
      @(negedge clk);
      check("R11 still none", {vval, req}, 0);
   endtask

   task automatic t_collide();
      do_reset();
      en = 8'h81; ext_edge[0] = 1;
      ext_n[0] = 0; repeat (4) @(negedge clk); ext_n[0] = 1; repeat (4) @(negedge clk);
      check("R9 collide pending", req, 1);
      ext_n[0] = 0;            // latched two edges later
      @(negedge clk);
      @(negedge clk);
      ack = 1; @(negedge clk); ack = 0;
      check("R9 collide vec valid", vval, 1);
      check("R9 collide vec", vaddr, 24'hFF0003);
      @(negedge clk);
      pulse_reti();
      check("R9 new edge beats clear", req, 1);
      ext_n[0] = 1;
   endtask

   initial begin
      t_reset();
      t_global();
      t_order();
      t_level();
      t_or();
      t_ext_level();
      t_ext_edge();
      t_preempt();
      t_ack_ignored();
      t_collide();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule